// File: doc/BRIEF.md
# SCCB Register-Access Master

A processor-facing bus master that reads and writes camera sensor registers over a two-wire SCCB link. Software fills a frame register and a timing register, then sets a run bit. The block then generates a start condition, shifts two to four bytes out MSB first and ends with a stop condition. It drives both SCL and SDA as open-drain lines, so the block only ever pulls a line low or releases it.

SCL timing comes from two counts in clock cycles, one for the low phase and one for the high phase. A register write with an 8-bit address is a three-byte frame. A write with a 16-bit address is a four-byte frame. A register read takes two separate runs. The first run sends the device and register address. The second run sends only the device address with its LSB set, clocks in one byte, answers it with a NACK and stores it where software can read it back.

A missing acknowledge from the sensor does not stop the frame. It only sets a sticky flag.

Top module: `sccb_master`

## Requirements
- R1: After reset, TIM (word 0) reads 255 in both SCL counts and length code 1. FRAME (word 1) reads 0. CTRL (word 2) reads 0. Neither line is pulled low.
- R2: SCL stays pulled low for TIM[7:0] clock cycles and stays released for TIM[15:8] cycles in each data bit. A count below 2 acts as 2.
- R3: For a write frame (device byte LSB 0), TIM[17:16] selects the byte count: 0 gives 2 bytes, 1 gives 3, and 2 or 3 give 4. The bytes go out as FRAME[7:0] (device), FRAME[15:8] (register address), FRAME[23:16], then FRAME[31:24].
- R4: Every byte is sent MSB first. A ninth clock follows each byte, with SDA released so the slave can acknowledge. A 16-bit-address write therefore shows high address, low address, value in the last three byte slots.
- R5: When the device byte LSB is 1, the frame has exactly 2 bytes whatever the length code. After the device byte the master releases SDA for 8 clocks and samples the bits MSB first. It leaves the ninth clock released (NACK) and stores the byte in TIM[31:24].
- R6: Writing CTRL (word 2) with both bit0 and bit1 set starts a frame. CTRL bit0 then reads 1 until the stop condition completes. A write with bit1 clear starts nothing.
- R7: CTRL bit2 is set when the acknowledge slot of a transmitted byte samples SDA high. The frame still runs to its end. The bit stays set until software writes CTRL with bit3 set.
- R8: While CTRL bit0 reads 1, writes to TIM and FRAME have no effect.
- R9: When idle, both lines are released. A frame opens with SDA pulled low while SCL is released. It closes with SDA released while SCL is released, after SDA was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; the SCL counts are in its cycles |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word index (0 TIM, 1 FRAME, 2 CTRL) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the register selected by reg_addr_i |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
The bench aims first at the phase counts. It measures SCL low and high runs at the reset rate of 255, at small counts, and at counts of 0 and 1. A design that omits the clamp would collapse a phase to nothing or would let SDA move together with SCL.

Byte-count decoding is checked for every length code, including the spare code 3. A wrong decode would drop the last data bytes or swap their order.

The read run is driven with a slave model that returns known data. A master that drives the ninth clock, or honours the length code on a read, would show a wrong ACK bit or an extra byte in the scoreboard. A master that shifts in the wrong order would return a bit-reversed value.

Writes to TIM and FRAME during a busy frame, a start without its companion bit, and a NACK followed by a clean frame are each checked. These catch registers that are not frozen, stray starts, and a non-sticky flag.

// File: rtl/sccb_pkg.sv
package sccb_pkg;
  localparam int REG_W  = 32;
  localparam int REG_AW = 2;

  localparam logic [REG_AW-1:0] A_TIM   = 2'd0;
  localparam logic [REG_AW-1:0] A_FRAME = 2'd1;
  localparam logic [REG_AW-1:0] A_CTRL  = 2'd2;

  typedef struct packed {
    logic [7:0] wd1;
    logic [7:0] wd0;
    logic [7:0] sub;
    logic [7:0] dev;
  } frame_t;

  typedef enum logic [2:0] {
    E_IDLE, E_START, E_LOW, E_HIGH, E_STOP_LOW, E_STOP_HIGH
  } eng_state_e;
endpackage

// File: rtl/sccb_regs.sv
module sccb_regs import sccb_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              busy_o,
  output logic              go_o,
  output logic [CNT_W-1:0]  lo_o,
  output logic [CNT_W-1:0]  hi_o,
  output logic [1:0]        len_o,
  output frame_t            frame_o,
  input  logic              done_i,
  input  logic              nack_i,
  input  logic              rd_we_i,
  input  logic [7:0]        rd_data_i
);
  localparam logic [CNT_W-1:0] CNT_RST = '1;

  logic       run_q, nack_q;
  logic [7:0] rx_q;

  assign busy_o = run_q;
  assign go_o   = we_i && (addr_i == A_CTRL) && wdata_i[0] && wdata_i[1] && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o    <= CNT_RST;
      hi_o    <= CNT_RST;
      len_o   <= 2'd1;
      frame_o <= '0;
      run_q   <= 1'b0;
      nack_q  <= 1'b0;
      rx_q    <= '0;
    end else begin
      if (we_i && !run_q && addr_i == A_TIM) begin
        lo_o  <= wdata_i[CNT_W-1:0];
        hi_o  <= wdata_i[8 +: CNT_W];
        len_o <= wdata_i[17:16];
      end
      if (we_i && !run_q && addr_i == A_FRAME) frame_o <= frame_t'(wdata_i);
      if (nack_i)                                         nack_q <= 1'b1;
      else if (we_i && addr_i == A_CTRL && wdata_i[3])    nack_q <= 1'b0;
      if (go_o)        run_q <= 1'b1;
      else if (done_i) run_q <= 1'b0;
      if (rd_we_i) rx_q <= rd_data_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_TIM: begin
        rdata_o[CNT_W-1:0] = lo_o;
        rdata_o[8 +: CNT_W] = hi_o;
        rdata_o[17:16]      = len_o;
        rdata_o[31:24]      = rx_q;
      end
      A_FRAME: rdata_o = REG_W'(frame_o);
      A_CTRL:  rdata_o[2:0] = {nack_q, 1'b0, run_q};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/sccb_phase_timer.sv
module sccb_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i - CNT_W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/sccb_engine.sv
module sccb_engine import sccb_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [1:0]       len_i,
  input  frame_t           frame_i,
  input  logic             sda_i,
  input  logic             expire_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_len_o,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             done_o,
  output logic             nack_o,
  output logic             rd_we_o,
  output logic [7:0]       rd_data_o
);
  localparam logic [CNT_W-1:0] MIN_PH  = CNT_W'(2);
  localparam logic [3:0]       ACK_BIT = 4'd8;

  eng_state_e st_q;
  logic [3:0] bit_q;
  logic [1:0] byte_q;
  logic [2:0] nb_q;
  logic       rd_q, sda_q;
  logic [7:0] tx_q, rx_q;
  logic [CNT_W-1:0] lo_eff, hi_eff;
  logic       last_byte, rd_byte, ack_end;

  function automatic logic [7:0] pick(input logic [1:0] idx, input frame_t f, input logic rd);
    logic [7:0] b;
    unique case (idx)
      2'd0: b = f.dev;
      2'd1: b = f.sub;
      2'd2: b = f.wd0;
      default: b = f.wd1;
    endcase
    // read byte: keep SDA released for the slave
    if (rd && idx != 2'd0) b = 8'hFF;
    return b;
  endfunction

  assign lo_eff    = (lo_i < MIN_PH) ? MIN_PH : lo_i;
  assign hi_eff    = (hi_i < MIN_PH) ? MIN_PH : hi_i;
  assign last_byte = (({1'b0, byte_q} + 3'd1) == nb_q);
  assign rd_byte   = rd_q && (byte_q != 2'd0);
  assign ack_end   = (st_q == E_HIGH) && expire_i && (bit_q == ACK_BIT);

  assign tmr_load_o = (st_q == E_IDLE) ? go_i : (expire_i && st_q != E_STOP_HIGH);
  assign tmr_len_o  = (st_q == E_START || st_q == E_HIGH) ? lo_eff : hi_eff;

  assign scl_oe_o  = (st_q == E_LOW) || (st_q == E_STOP_LOW);
  assign sda_oe_o  = sda_q;
  assign done_o    = (st_q == E_STOP_HIGH) && expire_i;
  assign nack_o    = ack_end && !rd_byte && sda_i;
  assign rd_we_o   = ack_end && rd_byte;
  assign rd_data_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= E_IDLE;
      bit_q  <= '0;
      byte_q <= '0;
      nb_q   <= '0;
      rd_q   <= 1'b0;
      sda_q  <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      unique case (st_q)
        E_IDLE: begin
          sda_q <= 1'b0;
          if (go_i) begin
            st_q   <= E_START;
            tx_q   <= frame_i.dev;
            bit_q  <= '0;
            byte_q <= '0;
            rd_q   <= frame_i.dev[0];
            if (frame_i.dev[0] || len_i == 2'd0) nb_q <= 3'd2;
            else if (len_i == 2'd1)              nb_q <= 3'd3;
            else                                 nb_q <= 3'd4;
          end
        end
        E_START: begin
          sda_q <= 1'b1;
          if (expire_i) st_q <= E_LOW;
        end
        E_LOW: begin
          // update SDA only after SCL has been low for a cycle
          sda_q <= (bit_q < ACK_BIT) && !tx_q[7];
          if (expire_i) st_q <= E_HIGH;
        end
        E_HIGH: begin
          if (expire_i) begin
            if (bit_q == ACK_BIT) begin
              if (last_byte) st_q <= E_STOP_LOW;
              else begin
                st_q   <= E_LOW;
                byte_q <= byte_q + 2'd1;
                bit_q  <= '0;
                tx_q   <= pick(byte_q + 2'd1, frame_i, rd_q);
              end
            end else begin
              st_q  <= E_LOW;
              tx_q  <= {tx_q[6:0], 1'b1};
              rx_q  <= {rx_q[6:0], sda_i};
              bit_q <= bit_q + 4'd1;
            end
          end
        end
        E_STOP_LOW: begin
          sda_q <= 1'b1;
          if (expire_i) st_q <= E_STOP_HIGH;
        end
        E_STOP_HIGH: begin
          if (expire_i) begin
            sda_q <= 1'b0;
            st_q  <= E_IDLE;
          end
        end
        default: st_q <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sccb_master.sv
module sccb_master import sccb_pkg::*; #(
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  localparam int CFG_W = 2 * CNT_W + 2 + $bits(frame_t);

  logic             busy, go, done, nack, rd_we, tmr_load, tmr_exp;
  logic [CNT_W-1:0] scl_lo, scl_hi, tmr_len;
  logic [1:0]       len_code;
  logic [7:0]       rd_data;
  frame_t           frame;
  logic [CFG_W-1:0] cfg_vec;

  assign cfg_vec = {scl_lo, scl_hi, len_code, frame};

  sccb_regs #(.CNT_W(CNT_W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_o(busy), .go_o(go), .lo_o(scl_lo), .hi_o(scl_hi), .len_o(len_code),
    .frame_o(frame), .done_i(done), .nack_i(nack), .rd_we_i(rd_we), .rd_data_i(rd_data)
  );

  sccb_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .len_i(tmr_len), .expire_o(tmr_exp)
  );

  sccb_engine #(.CNT_W(CNT_W)) i_engine (
    .clk_i, .rst_ni, .go_i(go), .lo_i(scl_lo), .hi_i(scl_hi), .len_i(len_code),
    .frame_i(frame), .sda_i, .expire_i(tmr_exp), .tmr_load_o(tmr_load), .tmr_len_o(tmr_len),
    .scl_oe_o, .sda_oe_o, .done_o(done), .nack_o(nack), .rd_we_o(rd_we), .rd_data_o(rd_data)
  );
endmodule

// File: rtl/sccb_master_chk.sv
module sccb_master_chk #(
  parameter int CFG_W = 50
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             scl_oe_i,
  input logic             sda_oe_i,
  input logic [CFG_W-1:0] cfg_i
);
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!scl_oe_i && !sda_oe_i)); // R9

  AST_START_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |=> (sda_oe_i && !scl_oe_i)); // R9

  AST_STOP_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> ($past(sda_oe_i) && !$past(scl_oe_i))); // R9

  AST_LOW_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_i) |=> scl_oe_i); // R2

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(cfg_i)); // R8
endmodule

bind sccb_master sccb_master_chk #(.CFG_W(CFG_W)) i_sccb_master_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy),
  .scl_oe_i(scl_oe_o), .sda_oe_i(sda_oe_o), .cfg_i(cfg_vec)
);

// File: tb/test_sccb_master.sv
module test_sccb_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        scl_oe, sda_oe;
  logic        slv_low = 1'b0;
  logic        scl_line, sda_line;

  always #2.5 clk = ~clk;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slv_low);

  sccb_master i_sccb_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sda_i(sda_line), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  int n_cmp = 0, n_bad = 0;
  logic [8:0] exp_q[$];
  int         len_q[$];
  logic       ack_en = 1'b1;
  logic [7:0] rd_val = 8'h00;
  logic [7:0] cur_lo = 8'hFF, cur_hi = 8'hFF;
  int         last_lo = 0, last_hi = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus monitor and slave model
  logic p_scl = 1'b1, p_sda = 1'b1, in_fr = 1'b0, rdm = 1'b0, ackb = 1'b0;
  int   bitc = 0, bytec = 0, lowc = 0, highc = 0;
  logic [7:0] sh = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!p_scl && scl_line) begin
        if (in_fr) last_lo = lowc;
        lowc = 0; highc = 0;
      end else if (p_scl && !scl_line) begin
        if (in_fr && bitc > 0) last_hi = highc;
        lowc = 0; highc = 0;
      end
      if (scl_line) highc++; else lowc++;

      if (p_scl && scl_line && p_sda && !sda_line) begin
        in_fr = 1'b1; bitc = 0; bytec = 0; rdm = 1'b0;
      end else if (p_scl && scl_line && !p_sda && sda_line && in_fr) begin
        in_fr = 1'b0;
        if (len_q.size() == 0) check(0, "R9 unexpected frame", bytec, 0);
        else begin
          int el;
          el = len_q.pop_front();
          check(bytec == el, "R3 bytes per frame", bytec, el);
        end
      end else if (in_fr && !p_scl && scl_line) begin
        if (bitc < 8) sh = {sh[6:0], sda_line};
        else ackb = sda_line;
        bitc++;
      end else if (in_fr && p_scl && !scl_line) begin
        if (bitc == 9) begin
          if (exp_q.size() == 0) check(0, "R4 unexpected byte", {ackb, sh}, 0);
          else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            check({ackb, sh} == e, "R4 byte and ack slot", {ackb, sh}, e);
          end
          if (bytec == 0) rdm = sh[0];
          bytec++;
          bitc = 0;
        end
        if (bitc == 8)                         slv_low = !(rdm && bytec == 1) && ack_en;
        else if (bitc < 8 && rdm && bytec == 1) slv_low = !rd_val[7 - bitc];
        else                                   slv_low = 1'b0;
      end
    end
    p_scl = scl_line;
    p_sda = sda_line;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int n = 0;
    do begin rd(2'd2, s); n++; end while (s[0] && n < 60000);
    check(!s[0], "R6 run bit clears", s[0], 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_tim(input logic [7:0] lo, input logic [7:0] hi, input logic [1:0] code);
    cur_lo = lo; cur_hi = hi;
    wr(2'd0, {14'd0, code, hi, lo});
  endtask

  // driver: queue the expected bytes, then run one frame
  task automatic run_frame(input logic [7:0] dv, input logic [7:0] sb, input logic [7:0] d0,
                           input logic [7:0] d1, input int nb);
    logic [7:0] b[4];
    b[0] = dv; b[1] = sb; b[2] = d0; b[3] = d1;
    for (int i = 0; i < nb; i++) begin
      if (dv[0] && i == 1) exp_q.push_back({1'b1, rd_val});
      else                 exp_q.push_back({!ack_en, b[i]});
    end
    len_q.push_back(nb);
    wr(2'd1, {d1, d0, sb, dv});
    wr(2'd2, 32'h3);
    wait_idle();
    check(exp_q.size() == 0 && len_q.size() == 0, "R3 all bytes seen", exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd0, v);
    check(v[17:0] == 18'h1FFFF, "R1 TIM reset", v[17:0], 18'h1FFFF);
    rd(2'd1, v);
    check(v == 0, "R1 FRAME reset", v, 0);
    rd(2'd2, v);
    check(v == 0, "R1 CTRL reset", v, 0);
    check(!scl_oe && !sda_oe, "R9 idle lines released", {scl_oe, sda_oe}, 0);

    // default slow rate, 2-byte frame
    set_tim(8'hFF, 8'hFF, 2'd0);
    run_frame(8'h60, 8'h12, 8'h00, 8'h00, 2);
    check(last_lo == 255, "R2 low phase at reset count", last_lo, 255);
    check(last_hi == 255, "R2 high phase at reset count", last_hi, 255);

    set_tim(8'd4, 8'd6, 2'd1);
    run_frame(8'h60, 8'h12, 8'h80, 8'h55, 3);
    check(last_lo == 4, "R2 low phase", last_lo, 4);
    check(last_hi == 6, "R2 high phase", last_hi, 6);

    // 16-bit address write, R4 order
    set_tim(8'd4, 8'd6, 2'd2);
    run_frame(8'h78, 8'h30, 8'h08, 8'h82, 4);
    set_tim(8'd4, 8'd6, 2'd3);
    run_frame(8'h42, 8'hA5, 8'h5A, 8'hC3, 4);

    // clamp of tiny counts
    set_tim(8'd1, 8'd0, 2'd1);
    run_frame(8'h60, 8'h0F, 8'hF0, 8'h00, 3);
    check(last_lo == 2, "R2 low clamp", last_lo, 2);
    check(last_hi == 2, "R2 high clamp", last_hi, 2);
    rd(2'd2, v);
    check(v[2] == 1'b0, "R7 no nack after acked frames", v[2], 0);

    // R5 reads: length code 2 must be ignored on the read run
    set_tim(8'd3, 8'd5, 2'd0);
    run_frame(8'h60, 8'h1D, 8'h00, 8'h00, 2);
    rd_val = 8'hA2;
    set_tim(8'd3, 8'd5, 2'd2);
    run_frame(8'h61, 8'h00, 8'h00, 8'h00, 2);
    rd(2'd0, v);
    check(v[31:24] == 8'hA2, "R5 read data", v[31:24], 8'hA2);
    set_tim(8'd3, 8'd5, 2'd1);
    run_frame(8'h60, 8'h12, 8'h34, 8'h00, 3);
    rd_val = 8'h5C;
    run_frame(8'h61, 8'h00, 8'h00, 8'h00, 2);
    rd(2'd0, v);
    check(v[31:24] == 8'h5C, "R5 second read data", v[31:24], 8'h5C);

    // R6 start without companion bit
    wr(2'd2, 32'h1);
    repeat (40) @(negedge clk);
    rd(2'd2, v);
    check(v[0] == 1'b0, "R6 start without we bit", v[0], 0);
    check(!in_fr && !scl_oe, "R6 no frame started", in_fr, 0);

    // R6 busy readback and R8 frozen registers
    set_tim(8'd4, 8'd4, 2'd2);
    exp_q.push_back({1'b0, 8'h60}); exp_q.push_back({1'b0, 8'h11});
    exp_q.push_back({1'b0, 8'h22}); exp_q.push_back({1'b0, 8'h33});
    len_q.push_back(4);
    wr(2'd1, 32'h33221160);
    wr(2'd2, 32'h3);
    rd(2'd2, v);
    check(v[0] == 1'b1, "R6 run bit set while busy", v[0], 1);
    wr(2'd1, 32'hDEADBEEF);
    wr(2'd0, 32'h0000_0101);
    wait_idle();
    check(exp_q.size() == 0, "R8 bus bytes unchanged", exp_q.size(), 0);
    rd(2'd1, v);
    check(v == 32'h33221160, "R8 FRAME frozen", v, 32'h33221160);
    rd(2'd0, v);
    check(v[17:0] == 18'h20404, "R8 TIM frozen", v[17:0], 18'h20404);

    // R7 sticky nack
    ack_en = 1'b0;
    set_tim(8'd3, 8'd3, 2'd0);
    run_frame(8'h60, 8'h77, 8'h00, 8'h00, 2);
    rd(2'd2, v);
    check(v[2] == 1'b1, "R7 nack flagged", v[2], 1);
    ack_en = 1'b1;
    run_frame(8'h60, 8'h78, 8'h00, 8'h00, 2);
    rd(2'd2, v);
    check(v[2] == 1'b1, "R7 nack sticky", v[2], 1);
    wr(2'd2, 32'h8);
    rd(2'd2, v);
    check(v[2] == 1'b0 && v[0] == 1'b0, "R7 nack cleared", v, 0);

    summary();
    $finish;
  end
endmodule